// File: doc/BRIEF.md
# Toggle Handshake Word Crossing

This block carries one data word at a time from a transmit clock domain into a receive clock domain whose clock has no fixed relation to it. Only one token exists between the two sides. The transmit side holds the token when its synchronised copy of the acknowledge equals its request. At that point it may load a new word into its data register and invert the request, both in the same cycle. The request then crosses into the receive domain through a chain of flip-flops. The receive side holds the token when its synchronised copy of the request differs from its acknowledge. It captures the word and later returns the token by copying the synchronised request onto its acknowledge. The acknowledge crosses back through a second flip-flop chain.

The sender sees a ready flag and a one-cycle send strobe. The consumer sees a one-cycle valid pulse that comes with the captured word. It gives the token back with a one-cycle accept. If the auto-accept option is set, the token goes back by itself. The transmit data register changes only on an accepted send, so the word on the crossing bus stays steady the whole time the receive side may sample it.

Top module: `tgl_xfer`

## Requirements
- R1: Every word taken on the send side is delivered on the receive side exactly once, in the order sent. No word is lost and none is repeated.
- R2: `snd_ready` is high exactly while the transmit side holds the token. It returns high only after the acknowledge of the last send has come back through the synchroniser.
- R3: A send is taken on a clock edge where `snd_strobe` and `snd_ready` are both high. The request inverts on that edge and `snd_ready` is low in the following cycle.
- R4: A `snd_strobe` while `snd_ready` is low is ignored. Its word is never delivered and the request does not change.
- R5: `rcv_valid` is high for one receive cycle per delivered word. During that cycle `rcv_word` equals the word the sender gave.
- R6: With `AUTO_ACCEPT` = 0, the acknowledge changes only on a receive edge where `rcv_accept` is high, while a word is held. The accept may come in the valid cycle or any later cycle. An accept with no word held is ignored. Until the accept arrives, `snd_ready` stays low and no further word is delivered.
- R7: With `AUTO_ACCEPT` = 1, the acknowledge changes on the receive edge that follows the valid pulse, with `rcv_accept` held low.
- R8: While either reset is asserted, the request, the acknowledge and every synchroniser stage are zero. Out of reset `snd_ready` is 1 and `rcv_valid` is 0.
- R9: The transmit data register changes only on a taken send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit domain clock |
| tx_rst_n | input | 1 | Transmit domain reset, active low, asynchronous |
| snd_strobe | input | 1 | Send request, one cycle |
| snd_word | input | DATA_W | Word to send |
| snd_ready | output | 1 | Transmit side holds the token |
| rx_clk | input | 1 | Receive domain clock |
| rx_rst_n | input | 1 | Receive domain reset, active low, asynchronous |
| rcv_valid | output | 1 | One-cycle pulse for a new word |
| rcv_word | output | DATA_W | Captured word |
| rcv_accept | input | 1 | Return the token (ignored when AUTO_ACCEPT = 1) |

## Verification
Two pairs of events can land in the same cycle. The first is an accept that arrives in the very cycle of the valid pulse. The bench produces it on every fourth word, with an accept delay of zero, and judges it by the next word still arriving once and in order. The second is a send strobe that arrives in the cycle right after a taken send, while ready is already low. The bench drives a garbage word at that moment. It judges the case by ready staying low and by that garbage word never appearing at the receive side. A further case is an accept pulsed while no word is held: ready must stay high afterwards and no valid pulse may appear.

// File: rtl/tgl_xfer_pkg.sv
package tgl_xfer_pkg;
   localparam int MIN_SYNC_STAGES = 2;

   typedef enum logic {
      RX_IDLE = 1'b0,
      RX_HELD = 1'b1
   } rx_state_e;
endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tgl_tx_side.sv
module tgl_tx_side #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snd_strobe,
   input  logic [DATA_W-1:0] snd_word,
   input  logic              ack_sync,
   output logic              snd_ready,
   output logic              tx_req,
   output logic [DATA_W-1:0] tx_data
);
   logic              req_q;
   logic [DATA_W-1:0] data_q;
   logic              take;

   assign snd_ready = (ack_sync == req_q);
   assign take      = snd_strobe & snd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         data_q <= '0;
      end else if (take) begin
         req_q  <= ~req_q;
         data_q <= snd_word;
      end
   end

   assign tx_req  = req_q;
   assign tx_data = data_q;
endmodule

// File: rtl/tgl_rx_side.sv
module tgl_rx_side
   import tgl_xfer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit AUTO_ACCEPT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_sync,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              rcv_accept,
   output logic              rx_ack,
   output logic              rcv_valid,
   output logic [DATA_W-1:0] rcv_word
);
   rx_state_e         st_q;
   logic              ack_q;
   logic              valid_q;
   logic [DATA_W-1:0] word_q;
   logic              own;
   logic              release_ok;

   assign own        = (req_sync != ack_q);
   assign release_ok = AUTO_ACCEPT ? 1'b1 : rcv_accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         ack_q   <= 1'b0;
         valid_q <= 1'b0;
         word_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         case (st_q)
            RX_IDLE: if (own) begin
               word_q  <= bus_data;
               valid_q <= 1'b1;
               st_q    <= RX_HELD;
            end
            RX_HELD: if (release_ok) begin
               ack_q <= req_sync;
               st_q  <= RX_IDLE;
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign rx_ack    = ack_q;
   assign rcv_valid = valid_q;
   assign rcv_word  = word_q;
endmodule

// File: rtl/tgl_xfer.sv
module tgl_xfer
   import tgl_xfer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit AUTO_ACCEPT = 1'b0
) (
   input  logic              tx_clk,
   input  logic              tx_rst_n,
   input  logic              snd_strobe,
   input  logic [DATA_W-1:0] snd_word,
   output logic              snd_ready,
   input  logic              rx_clk,
   input  logic              rx_rst_n,
   output logic              rcv_valid,
   output logic [DATA_W-1:0] rcv_word,
   input  logic              rcv_accept
);
   localparam int SYNC_W = 1;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("tgl_xfer: SYNC_STAGES below minimum");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tgl_xfer: DATA_W must be positive");
   end

   logic              tx_req;
   logic [DATA_W-1:0] tx_data;
   logic              rx_ack;
   logic              req_sync;
   logic              ack_sync;

   tgl_tx_side #(.DATA_W(DATA_W)) u_tx (
      .clk(tx_clk), .rst_n(tx_rst_n),
      .snd_strobe(snd_strobe), .snd_word(snd_word),
      .ack_sync(ack_sync), .snd_ready(snd_ready),
      .tx_req(tx_req), .tx_data(tx_data)
   );

   tgl_sync #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) u_req_sync (
      .clk(rx_clk), .rst_n(rx_rst_n), .d(tx_req), .q(req_sync)
   );

   tgl_sync #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) u_ack_sync (
      .clk(tx_clk), .rst_n(tx_rst_n), .d(rx_ack), .q(ack_sync)
   );

   tgl_rx_side #(.DATA_W(DATA_W), .AUTO_ACCEPT(AUTO_ACCEPT)) u_rx (
      .clk(rx_clk), .rst_n(rx_rst_n),
      .req_sync(req_sync), .bus_data(tx_data),
      .rcv_accept(rcv_accept), .rx_ack(rx_ack),
      .rcv_valid(rcv_valid), .rcv_word(rcv_word)
   );
endmodule

// File: rtl/tgl_xfer_chk.sv
module tgl_xfer_chk #(
   parameter int DATA_W      = 8,
   parameter bit AUTO_ACCEPT = 1'b0
) (
   input logic              tx_clk,
   input logic              tx_rst_n,
   input logic              rx_clk,
   input logic              rx_rst_n,
   input logic              snd_strobe,
   input logic              snd_ready,
   input logic              tx_req,
   input logic [DATA_W-1:0] tx_data,
   input logic              rx_ack,
   input logic              rcv_valid,
   input logic [DATA_W-1:0] rcv_word,
   input logic              rcv_accept
);
   always @(posedge tx_clk) begin
      if (!tx_rst_n) begin
         AST_TX_RESET_STATE: assert (!tx_req && snd_ready); // R8
      end
   end

   always @(posedge rx_clk) begin
      if (!rx_rst_n) begin
         AST_RX_RESET_STATE: assert (!rx_ack && !rcv_valid); // R8
      end
   end

   AST_SEND_TOGGLES: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      (snd_strobe && snd_ready) |=> (tx_req != $past(tx_req)) && !snd_ready); // R3

   AST_IDLE_HOLDS: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      !(snd_strobe && snd_ready) |=> $stable(tx_req) && $stable(tx_data)); // R9

   AST_VALID_PULSE: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      rcv_valid |=> !rcv_valid); // R5

   AST_DATA_MATCH: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      rcv_valid |-> (rcv_word == tx_data)); // R5

   AST_ACK_NEEDS_ACCEPT: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      (!AUTO_ACCEPT && !rcv_accept) |=> $stable(rx_ack)); // R6

   AST_AUTO_RELEASE: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      (AUTO_ACCEPT && rcv_valid) |=> (rx_ack != $past(rx_ack))); // R7
endmodule

bind tgl_xfer tgl_xfer_chk #(.DATA_W(DATA_W), .AUTO_ACCEPT(AUTO_ACCEPT)) u_chk (
   .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
   .snd_strobe(snd_strobe), .snd_ready(snd_ready), .tx_req(tx_req),
   .tx_data(tx_data), .rx_ack(rx_ack), .rcv_valid(rcv_valid),
   .rcv_word(rcv_word), .rcv_accept(rcv_accept)
);

// File: tb/tgl_xfer_test.sv
module tgl_xfer_test;
   localparam int W = 8;
   localparam int N = 256;

   logic tx_clk = 1'b0, rx_clk = 1'b0;
   logic tx_rst_n = 1'b0, rx_rst_n = 1'b0;
   always #5 tx_clk = ~tx_clk;
   always #3.5 rx_clk = ~rx_clk;

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] wexp(input int i);
      return W'((i * 73 + 11) % 256);
   endfunction

   // instance with explicit accept
   logic a_strobe = 1'b0, a_accept = 1'b0;
   logic [W-1:0] a_word = '0, a_rword;
   logic a_ready, a_valid;
   tgl_xfer #(.DATA_W(W), .SYNC_STAGES(2), .AUTO_ACCEPT(1'b0)) uut (
      .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .snd_strobe(a_strobe), .snd_word(a_word),
      .snd_ready(a_ready), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
      .rcv_valid(a_valid), .rcv_word(a_rword), .rcv_accept(a_accept));

   // instance with auto accept
   logic b_strobe = 1'b0, b_accept = 1'b0;
   logic [W-1:0] b_word = '0, b_rword;
   logic b_ready, b_valid;
   tgl_xfer #(.DATA_W(W), .SYNC_STAGES(2), .AUTO_ACCEPT(1'b1)) uut_auto (
      .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .snd_strobe(b_strobe), .snd_word(b_word),
      .snd_ready(b_ready), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
      .rcv_valid(b_valid), .rcv_word(b_rword), .rcv_accept(b_accept));

   int a_cnt = 0, b_cnt = 0;
   bit a_pend = 0, a_hold = 0, a_poke = 0, a_prev = 0, b_prev = 0;
   int a_dly = 0;

   // receive monitor, explicit accept
   always @(negedge rx_clk) begin
      a_accept = 1'b0;
      if (rx_rst_n) begin
         if (a_valid) begin
            chk(!a_prev, "R5 valid one cycle", 1, 0);
            chk(a_cnt <= N, "R1 no extra word", a_cnt, N);
            chk(a_rword == wexp(a_cnt), "R1/R5 word order", a_rword, wexp(a_cnt));
            a_pend = 1;
            a_dly = a_cnt % 4;
            a_cnt++;
         end
         a_prev = a_valid;
         if (a_pend && !a_hold) begin
            if (a_dly == 0) begin
               a_accept = 1'b1;
               a_pend = 0;
            end else a_dly--;
         end else if (!a_pend && a_poke) begin
            a_accept = 1'b1;  // R6 accept with nothing held
            a_poke = 0;
         end
      end
   end

   // receive monitor, auto accept (R7)
   always @(negedge rx_clk) begin
      if (rx_rst_n && b_valid) begin
         chk(!b_prev, "R5 auto valid one cycle", 1, 0);
         chk(b_rword == wexp(b_cnt), "R7 auto word order", b_rword, wexp(b_cnt));
         b_cnt++;
      end
      b_prev = rx_rst_n && b_valid;
   end

   task automatic send_a(input int i, input bit junk);
      while (!a_ready) @(negedge tx_clk);
      a_word = wexp(i);
      a_strobe = 1'b1;
      @(negedge tx_clk);
      chk(!a_ready, "R3 ready drops after send", a_ready, 0);
      if (junk) begin
         a_word = ~wexp(i) ^ 8'h5A;  // R4 strobe while busy
         @(negedge tx_clk);
         chk(!a_ready, "R4 busy strobe ignored", a_ready, 0);
      end
      a_strobe = 1'b0;
   endtask

   initial begin : watchdog
      #1500000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1;
      chk(a_ready == 1'b1, "R8 ready in reset", a_ready, 1);
      chk(a_valid == 1'b0, "R8 valid in reset", a_valid, 0);
      chk(b_ready == 1'b1, "R8 auto ready in reset", b_ready, 1);
      #50;
      @(negedge tx_clk) tx_rst_n = 1'b1;
      @(negedge rx_clk) rx_rst_n = 1'b1;
      @(negedge tx_clk);
      chk(a_ready == 1'b1, "R8 ready after reset", a_ready, 1);
      fork
         begin
            for (int i = 0; i < N; i++) send_a(i, (i % 3) == 1);
            while (!a_ready) @(negedge tx_clk);
            // accept while idle must not move the token
            a_poke = 1;
            repeat (10) @(negedge tx_clk);
            chk(a_ready == 1'b1, "R6 idle accept ignored", a_ready, 1);
            chk(a_cnt == N, "R6 no valid from idle accept", a_cnt, N);
            a_hold = 1;
            send_a(N, 1'b0);
            repeat (40) @(negedge tx_clk);
            chk(a_ready == 1'b0, "R2/R6 ready waits for accept", a_ready, 0);
            chk(a_cnt == N + 1, "R6 held word delivered once", a_cnt, N + 1);
            a_hold = 0;
            repeat (30) @(negedge tx_clk);
            chk(a_ready == 1'b1, "R2 ready after ack returns", a_ready, 1);
         end
         begin
            for (int i = 0; i < N; i++) begin
               while (!b_ready) @(negedge tx_clk);
               b_word = wexp(i);
               b_strobe = 1'b1;
               @(negedge tx_clk);
               chk(!b_ready, "R3 auto ready drops", b_ready, 0);
               b_strobe = 1'b0;
            end
         end
      join
      repeat (40) @(negedge tx_clk);
      chk(a_cnt == N + 1, "R1 total delivered", a_cnt, N + 1);
      chk(b_cnt == N, "R7 auto total delivered", b_cnt, N);
      chk(b_ready == 1'b1, "R7 auto token returned", b_ready, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule